// File: doc/BRIEF.md
# Flash Programming Clock Divider

This block derives the slow clock that paces flash program and erase operations from the fast system bus clock. Software writes a 12-bit divide setting N through a simple word-wide register port. With N at zero the block stays idle and delivers no programming clock. With N nonzero it repeats a period of 3·N+1 bus cycles. In each period it produces a one-cycle enable pulse and a square-wave clock whose frequency is the bus frequency divided by 3·N+1.

Software picks N so that the result sits near the frequency window the flash array needs. The block does not check that window. A new nonzero setting waits until the current period has finished before it applies, so the output never has a shortened or stretched cycle. Writing zero halts the output at once and clears the period counter.

Top module: `fpc_divider`

## Requirements
- R1: After reset the setting reads 0 and both `prog_tick` and `prog_clk` are low.
- R2: A write stores `wr_data[11:0]` as the setting, and from the cycle after the write `rd_data` returns it in bits 11:0. Bits 31:12 of a write are ignored and always read back as 0.
- R3: While the stored setting is 0, `prog_tick` and `prog_clk` stay low from the next cycle onward.
- R4: With a stable nonzero setting N, `prog_tick` is high for exactly one cycle in every 3·N+1 cycles.
- R5: With a stable nonzero setting N, `prog_clk` is high for the first ceil((3·N+1)/2) cycles of each period and low for the rest. It rises in the cycle that follows a `prog_tick` cycle.
- R6: A new nonzero setting written while the output runs leaves the current period at its old length. The new length applies from the period that starts after the next `prog_tick`.
- R7: Writing 0 while the output runs forces both outputs low by the second cycle after the write. No further tick occurs.
- R8: When the setting changes from 0 to N, the first period starts one cycle after the setting becomes visible on `rd_data`: `prog_clk` goes high and the first `prog_tick` follows 3·N cycles later.
- R9: The largest setting, 4095, gives a tick spacing of 12286 cycles with no counter overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| wr_en | input | 1 | Write strobe for the divide setting |
| wr_data | input | 32 | Write data; only bits 11:0 are kept |
| rd_data | output | 32 | Read-back of the setting, upper bits zero |
| prog_tick | output | 1 | One-cycle enable pulse per programming-clock period |
| prog_clk | output | 1 | Programming clock square wave, low when idle |

## Verification
A bad period counter or captured limit shows at the ports within one period. The next `prog_tick` comes early or late, and the `prog_clk` duty edge moves. A model that compares every cycle therefore catches it no later than 3·N+1 cycles after the fault. A bad stop path shows within two cycles of writing zero, because the outputs fail to drop. A bad hand-over at a period boundary shows as a wrong-length period right after a mid-period rewrite. The bench provokes this on purpose by rewriting the setting several times in mid-period.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned FPC_DIV_W = 12;
  localparam int unsigned FPC_BUS_W = 32;
endpackage

// File: rtl/fpc_cfg_reg.sv
module fpc_cfg_reg #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [DIV_W-1:0] cfg_o,
  output logic [BUS_W-1:0] rd_data
);
  localparam int unsigned PAD_W = BUS_W - DIV_W;

  logic [DIV_W-1:0] cfg_q;
  logic [DIV_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o   = cfg_q;
  assign rd_data = {{PAD_W{1'b0}}, cfg_q};

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[DIV_W-1:0] == $past(wr_data[DIV_W-1:0])));

  assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/fpc_period_ctr.sv
module fpc_period_ctr #(
  parameter int unsigned DIV_W = 12,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_i,
  output logic             run_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic [CNT_W-1:0] lim_d_o,
  output logic [CNT_W-1:0] hi_d_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [CNT_W-1:0] hi_q,  hi_d;
  logic [CNT_W-1:0] cfg_ext;
  logic [CNT_W-1:0] new_lim;
  logic [CNT_W-1:0] new_hi;
  logic             cfg_zero;
  logic             at_wrap;

  // limit = 3*N, high phase = ceil((3N+1)/2) = (3N+2)>>1
  always_comb begin
    cfg_ext  = CNT_W'(cfg_i);
    new_lim  = (cfg_ext << 1) + cfg_ext;
    new_hi   = (new_lim + CNT_W'(2)) >> 1;
    cfg_zero = (cfg_i == '0);
    at_wrap  = run_q && (cnt_q == lim_q);
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    lim_d = lim_q;
    hi_d  = hi_q;
    if (cfg_zero) begin
      run_d = 1'b0;
      cnt_d = '0;
      lim_d = '0;
      hi_d  = '0;
    end else if (!run_q || at_wrap) begin
      run_d = 1'b1;
      cnt_d = '0;
      lim_d = new_lim;
      hi_d  = new_hi;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      lim_q <= '0;
      hi_q  <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      hi_q  <= hi_d;
    end
  end

  assign run_d_o = run_d;
  assign cnt_d_o = cnt_d;
  assign lim_d_o = lim_d;
  assign hi_d_o  = hi_d;

  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= lim_q));

  assert_zero_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_zero |=> (!run_q && cnt_q == '0));

  assert_limit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_wrap && !cfg_zero) |=> $stable(lim_q));

  assert_start_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cfg_zero) |=> (run_q && cnt_q == '0));
endmodule

// File: rtl/fpc_out_stage.sv
module fpc_out_stage #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic [CNT_W-1:0] lim_d_i,
  input  logic [CNT_W-1:0] hi_d_i,
  output logic             tick_o,
  output logic             clk_o
);
  logic tick_q, tick_d;
  logic pclk_q, pclk_d;

  always_comb begin
    tick_d = run_d_i && (cnt_d_i == lim_d_i);
    pclk_d = run_d_i && (cnt_d_i < hi_d_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      pclk_q <= pclk_d;
    end
  end

  assign tick_o = tick_q;
  assign clk_o  = pclk_q;

  assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  assert_tick_in_low_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> !pclk_q);
endmodule

// File: rtl/fpc_divider.sv
module fpc_divider
  import fpc_pkg::*;
#(
  parameter int unsigned DIV_W = FPC_DIV_W,
  parameter int unsigned BUS_W = FPC_BUS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             prog_tick,
  output logic             prog_clk
);
  localparam int unsigned MAX_LIM = 3 * ((1 << DIV_W) - 1);
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 2);

  logic [DIV_W-1:0] cfg;
  logic             run_d;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim_d;
  logic [CNT_W-1:0] hi_d;

  fpc_cfg_reg #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cfg_o   (cfg),
    .rd_data (rd_data)
  );

  fpc_period_ctr #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg),
    .run_d_o (run_d),
    .cnt_d_o (cnt_d),
    .lim_d_o (lim_d),
    .hi_d_o  (hi_d)
  );

  fpc_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_d_i (run_d),
    .cnt_d_i (cnt_d),
    .lim_d_i (lim_d),
    .hi_d_i  (hi_d),
    .tick_o  (prog_tick),
    .clk_o   (prog_clk)
  );

  assert_idle_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |=> (!prog_tick && !prog_clk));

  assert_clk_rises_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_tick && cfg != '0) |=> prog_clk);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:DIV_W] == '0);
endmodule

// File: tb/fpc_divider_test.sv
module fpc_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        prog_tick;
  logic        prog_clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural model
  int m_set = 0;
  bit m_on = 0;
  int m_pos = 0;
  int m_per = 0;

  always #2 clk = ~clk;

  fpc_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .prog_tick(prog_tick), .prog_clk(prog_clk)
  );

  always @(posedge clk) begin
    int old_set;
    cycles++;
    if (!rst_n) begin
      m_set = 0; m_on = 0; m_pos = 0; m_per = 0;
    end else begin
      old_set = m_set;
      if (old_set == 0) begin
        m_on = 0; m_pos = 0; m_per = 0;
      end else if (!m_on || m_pos == m_per - 1) begin
        m_on = 1; m_pos = 0; m_per = 3 * old_set + 1;
      end else begin
        m_pos++;
      end
      if (wr_en) m_set = int'(wr_data[11:0]);
    end
  end

  always @(negedge clk) begin
    bit e_tick, e_clk;
    if (rst_n) begin
      e_tick = m_on && (m_pos == m_per - 1);
      e_clk  = m_on && (m_pos < (m_per + 1) / 2);
      checks++;
      if (rd_data !== 32'(m_set)) begin
        errors++;
        $display("FAIL R2 rd_data got %h exp %h at cycle %0d", rd_data, m_set, cycles);
      end
      checks++;
      if (prog_tick !== e_tick) begin
        errors++;
        $display("FAIL R4/R6/R7 prog_tick got %b exp %b at cycle %0d", prog_tick, e_tick, cycles);
      end
      checks++;
      if (prog_clk !== e_clk) begin
        errors++;
        $display("FAIL R5/R3/R8 prog_clk got %b exp %b at cycle %0d", prog_clk, e_clk, cycles);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_set(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  // R9 / R4: distance between two ticks
  task automatic measure_gap(input string tag, input int exp);
    int a, b;
    a = 0; b = 0;
    while (prog_tick !== 1'b1) @(negedge clk);
    a = cycles;
    @(negedge clk);
    while (prog_tick !== 1'b1) @(negedge clk);
    b = cycles;
    check_val(tag, b - a, exp);
  endtask

  initial begin
    int t0;
    wait_cyc(3);
    // R1 reset state
    check_val("R1 rd_data", int'(rd_data), 0);
    check_val("R1 prog_tick", int'(prog_tick), 0);
    check_val("R1 prog_clk", int'(prog_clk), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check_val("R3 idle tick", int'(prog_tick), 0);

    // R2 upper bits ignored, R8 start
    write_set(32'hFFFF_F001);
    check_val("R2 readback", int'(rd_data), 1);
    t0 = cycles;
    @(negedge clk);
    check_val("R8 clk high at start", int'(prog_clk), 1);
    measure_gap("R4 gap N=1", 4);
    wait_cyc(3);

    // R6 mid-period rewrite
    write_set(32'd2);
    measure_gap("R6 gap after change N=2", 7);
    write_set(32'd5);
    wait_cyc(4);
    write_set(32'd3);
    measure_gap("R6 gap N=3", 10);

    // R7 stop mid-period
    wait_cyc(3);
    write_set(32'd0);
    @(negedge clk);
    check_val("R7 clk low", int'(prog_clk), 0);
    check_val("R7 tick low", int'(prog_tick), 0);
    wait_cyc(20);

    // R9 maximum setting
    write_set(32'h0000_0FFF);
    check_val("R9 readback", int'(rd_data), 4095);
    measure_gap("R9 gap N=4095", 12286);

    // restart sequence and reset while running
    write_set(32'd7);
    measure_gap("R4 gap N=7", 22);
    write_set(32'd1);
    wait_cyc(2);
    write_set(32'd0);
    write_set(32'd4);
    wait_cyc(30);
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    check_val("R1 reset mid-run clk", int'(prog_clk), 0);
    check_val("R1 reset mid-run cfg", int'(rd_data), 0);
    rst_n = 1'b1;
    wait_cyc(10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule